// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the control unit of a small accumulator computer whose datapath shares a single bus. A one-hot ring steps through six timing states. For each state the block decodes a 12-bit control word from the current ring state and the 4-bit opcode held in the instruction register. The control word steps the datapath through three phases: instruction fetch, operand address and operand fetch, and execute with write-back. Its outputs are the strobes for the program counter, the memory address register, the RAM, the instruction register, the accumulator, the operand register, the adder/subtractor and the output register.

A halt opcode stops the ring and raises a halted flag, which stays high until the clear input is asserted. Clear is synchronous and active high. The datapath registers and the memory are not part of this block.

The control word is a pure function of the ring state, the halted flag and the opcode. A state change is therefore visible on the word in the same cycle as the clock edge that causes it.

Top module: `accSequencer`

## Requirements
- R1: While `clr` is high at a rising edge, the ring returns to the first timing state and `halted` goes low at that edge. The first cycle after clear drives the word 0x804.
- R2: Word bit positions, from bit 11 down to bit 0: pcToBus, pcInc, irToBus, irLoad, accToBus, accLoad, subSel, aluToBus, opLoad, marLoad, ramToBus, outLoad. The first three timing states drive 0x804 (pcToBus, marLoad), then 0x400 (pcInc), then 0x102 (ramToBus, irLoad), whatever the opcode is.
- R3: For opcode 0000 (load), states 4 to 6 drive 0x204 (irToBus, marLoad), then 0x042 (ramToBus, accLoad), then 0x000.
- R4: For opcodes 0001 (add) and 0010 (subtract), states 4 and 5 drive 0x204 and then 0x00A (ramToBus, opLoad). State 6 drives 0x050 for add (aluToBus, accLoad) and 0x070 for subtract, which also sets subSel.
- R5: For opcode 0011 (output), state 4 drives 0x081 (accToBus, outLoad), and states 5 and 6 drive 0x000.
- R6: Opcode 1111 (halt) drives 0x000 in state 4. From the next edge on, `halted` is high, the ring is frozen and the word stays 0x000 whatever the opcode is, until `clr` is asserted.
- R7: Any other opcode drives 0x000 in states 4 to 6, and the ring then returns to the fetch state.
- R8: In every cycle, at most one of the bus drivers (pcToBus, irToBus, accToBus, aluToBus, ramToBus) is asserted.
- R9: While not halted, the ring has exactly one state active and advances one state per clock. The fetch word 0x804 therefore recurs every six cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear |
| opcode | input | 4 | Opcode field of the instruction register |
| ctrlWord | output | 12 | Control strobes, bit order as in R2 |
| halted | output | 1 | High once a halt opcode has been executed |

## Verification
The control word is combinational, so it is due in the same cycle the ring enters a state. The `halted` flag and the frozen ring appear one edge after state 4 sees the halt opcode, and clear takes effect at the first rising edge at which it is sampled high. The bench changes its inputs in the middle of the high phase. A behavioural model steps at each rising edge, and every output is compared with the model at the falling edge, so each check samples exactly one cycle's settled value. The sequences cover every defined opcode, several undefined ones, opcode changes while halted, and a restart after halt.

// File: rtl/accSeqPkg.sv
package accSeqPkg;
  localparam int OPC_W = 4;
  localparam int CW_W  = 12;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD = 4'b0000,
    OP_ADD  = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SHOW = 4'b0011,
    OP_STOP = 4'b1111
  } opcode_e;

  // Field order fixes bit order: pcToBus is bit 11, outLoad is bit 0.
  typedef struct packed {
    logic pcToBus;
    logic pcInc;
    logic irToBus;
    logic irLoad;
    logic accToBus;
    logic accLoad;
    logic subSel;
    logic aluToBus;
    logic opLoad;
    logic marLoad;
    logic ramToBus;
    logic outLoad;
  } strobes_t;
endpackage

// File: rtl/tStateRing.sv
module tStateRing #(
  parameter int NUM_T = 6
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             freeze,
  output logic [NUM_T-1:0] tState
);
  localparam logic [NUM_T-1:0] FIRST = NUM_T'(1);

  logic [NUM_T-1:0] rotated;
  logic             isOneHot;

  // Rotate by one place: the last state wraps back to the first.
  genvar i;
  generate
    for (i = 0; i < NUM_T; i++) begin : g_rot
      if (i == 0) begin : g_wrap
        assign rotated[i] = tState[NUM_T-1];
      end else begin : g_step
        assign rotated[i] = tState[i-1];
      end
    end
  endgenerate

  assign isOneHot = (tState != '0) && ((tState & (tState - FIRST)) == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      tState <= FIRST;
    end else if (!isOneHot) begin
      tState <= FIRST;
    end else if (!freeze) begin
      tState <= rotated;
    end
  end
endmodule

// File: rtl/ctrlDecode.sv
module ctrlDecode
  import accSeqPkg::*;
#(
  parameter int NUM_T = 6
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [OPC_W-1:0] opcode,
  input  logic [NUM_T-1:0] tState,
  output strobes_t         strobes,
  output logic             haltReg,
  output logic             freeze
);
  localparam int T_ADDR = 3;
  localparam int T_OPER = 4;
  localparam int T_EXEC = 5;

  logic isLoad, isAdd, isSub, isShow, isStop, isMem, isArith, stopNow;

  always_comb begin
    isLoad  = (opcode == OP_LOAD);
    isAdd   = (opcode == OP_ADD);
    isSub   = (opcode == OP_SUB);
    isShow  = (opcode == OP_SHOW);
    isStop  = (opcode == OP_STOP);
    isArith = isAdd | isSub;
    isMem   = isLoad | isArith;
  end

  assign stopNow = tState[T_ADDR] & isStop & ~haltReg;
  assign freeze  = haltReg | stopNow;

  always_ff @(posedge clk) begin
    if (clr) begin
      haltReg <= 1'b0;
    end else if (stopNow) begin
      haltReg <= 1'b1;
    end
  end

  always_comb begin
    strobes = '0;
    if (!haltReg) begin
      if (tState[0]) begin
        strobes.pcToBus = 1'b1;
        strobes.marLoad = 1'b1;
      end else if (tState[1]) begin
        strobes.pcInc = 1'b1;
      end else if (tState[2]) begin
        strobes.ramToBus = 1'b1;
        strobes.irLoad   = 1'b1;
      end else if (tState[T_ADDR]) begin
        if (isMem) begin
          strobes.irToBus = 1'b1;
          strobes.marLoad = 1'b1;
        end else if (isShow) begin
          strobes.accToBus = 1'b1;
          strobes.outLoad  = 1'b1;
        end
      end else if (tState[T_OPER]) begin
        if (isLoad) begin
          strobes.ramToBus = 1'b1;
          strobes.accLoad  = 1'b1;
        end else if (isArith) begin
          strobes.ramToBus = 1'b1;
          strobes.opLoad   = 1'b1;
        end
      end else if (tState[T_EXEC]) begin
        if (isArith) begin
          strobes.aluToBus = 1'b1;
          strobes.accLoad  = 1'b1;
          strobes.subSel   = isSub;
        end
      end
    end
  end
endmodule

// File: rtl/accSequencer.sv
module accSequencer
  import accSeqPkg::*;
#(
  parameter int NUM_T = 6
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [OPC_W-1:0] opcode,
  output logic [CW_W-1:0]  ctrlWord,
  output logic             halted
);
  logic [NUM_T-1:0] tState;
  logic             freeze;
  strobes_t         strobes;

  tStateRing #(.NUM_T(NUM_T)) ring_i (
    .clk    (clk),
    .clr    (clr),
    .freeze (freeze),
    .tState (tState)
  );

  ctrlDecode #(.NUM_T(NUM_T)) dec_i (
    .clk     (clk),
    .clr     (clr),
    .opcode  (opcode),
    .tState  (tState),
    .strobes (strobes),
    .haltReg (halted),
    .freeze  (freeze)
  );

  assign ctrlWord = strobes;
endmodule

// File: rtl/accSequencer_chk.sv
module accSequencer_chk #(
  parameter int NUM_T = 6
) (
  input logic             clk,
  input logic             clr,
  input logic [3:0]       opcode,
  input logic [11:0]      ctrlWord,
  input logic             halted,
  input logic [NUM_T-1:0] tState
);
  assert_clear_start_R1: assert property (@(posedge clk)
    clr |=> (tState == NUM_T'(1)) && !halted);

  assert_fetch_first_R2: assert property (@(posedge clk) disable iff (clr)
    (tState[0] && !halted) |-> ctrlWord == 12'h804);

  assert_load_oper_R3: assert property (@(posedge clk) disable iff (clr)
    (tState[4] && opcode == 4'b0000 && !halted) |-> ctrlWord == 12'h042);

  assert_sub_exec_R4: assert property (@(posedge clk) disable iff (clr)
    (tState[5] && opcode == 4'b0010 && !halted) |-> ctrlWord == 12'h070);

  assert_show_R5: assert property (@(posedge clk) disable iff (clr)
    (tState[3] && opcode == 4'b0011 && !halted) |-> ctrlWord == 12'h081);

  assert_halt_entry_R6: assert property (@(posedge clk) disable iff (clr)
    (tState[3] && opcode == 4'b1111 && !halted) |=> halted && $stable(tState));

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (clr)
    halted |=> halted);

  assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (clr)
    halted |-> ctrlWord == 12'h000);

  assert_undef_quiet_R7: assert property (@(posedge clk) disable iff (clr)
    ((tState[5:3] != 3'b000) && opcode > 4'b0011 && opcode < 4'b1111)
      |-> ctrlWord == 12'h000);

  assert_one_driver_R8: assert property (@(posedge clk) disable iff (clr)
    $countones({ctrlWord[11], ctrlWord[9], ctrlWord[7], ctrlWord[4], ctrlWord[1]}) <= 1);

  assert_ring_onehot_R9: assert property (@(posedge clk) disable iff (clr)
    $countones(tState) == 1);
endmodule

bind accSequencer accSequencer_chk #(.NUM_T(NUM_T)) chk_i (
  .clk      (clk),
  .clr      (clr),
  .opcode   (opcode),
  .ctrlWord (ctrlWord),
  .halted   (halted),
  .tState   (tState)
);

// File: tb/accSequencer_tb_top.sv
module accSequencer_tb_top;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [3:0]  opcode = 4'b0000;
  logic [11:0] ctrlWord;
  logic        halted;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int mT = 1;
  bit mH = 1'b0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  accSequencer dut_i (
    .clk      (clk),
    .clr      (clr),
    .opcode   (opcode),
    .ctrlWord (ctrlWord),
    .halted   (halted)
  );

  function automatic logic [11:0] expWord(int t, bit h, logic [3:0] op);
    if (h) return 12'h000;
    case (t)
      1: return 12'h804;
      2: return 12'h400;
      3: return 12'h102;
      4: return (op <= 4'd2) ? 12'h204 : (op == 4'd3) ? 12'h081 : 12'h000;
      5: return (op == 4'd0) ? 12'h042 : (op == 4'd1 || op == 4'd2) ? 12'h00A : 12'h000;
      6: return (op == 4'd1) ? 12'h050 : (op == 4'd2) ? 12'h070 : 12'h000;
      default: return 12'h000;
    endcase
  endfunction

  function automatic string reqTag(int t, bit h, logic [3:0] op, bit inClr);
    if (inClr) return "R1";
    if (h) return "R6";
    if (t == 1) return "R9";
    if (t <= 3) return "R2";
    if (op == 4'd0) return "R3";
    if (op == 4'd1 || op == 4'd2) return "R4";
    if (op == 4'd3) return "R5";
    if (op == 4'hF) return "R6";
    return "R7";
  endfunction

  // Behavioural reference: timing state number and halted flag.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    started <= 1'b1;
    if (clr) begin
      mT <= 1;
      mH <= 1'b0;
    end else if (mH) begin
      mT <= mT;
    end else if (mT == 4 && opcode == 4'hF) begin
      mH <= 1'b1;
    end else begin
      mT <= (mT == 6) ? 1 : mT + 1;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [11:0] e;
      string tag;
      e = expWord(mT, mH, opcode);
      tag = reqTag(mT, mH, opcode, clr);
      total++;
      if (ctrlWord !== e) begin
        bad++;
        $display("FAIL %s word state=T%0d op=%b actual=%h expected=%h", tag, mT, opcode, ctrlWord, e);
      end
      total++;
      if (halted !== mH) begin
        bad++;
        $display("FAIL %s halted actual=%b expected=%b", mH ? "R6" : tag, halted, mH);
      end
      total++; // R8 bus driver exclusivity
      if ($countones({ctrlWord[11], ctrlWord[9], ctrlWord[7], ctrlWord[4], ctrlWord[1]}) > 1) begin
        bad++;
        $display("FAIL R8 drivers actual=%h expected=at most one driver", ctrlWord);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d cycles expected=under 5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runInstr(input logic [3:0] op);
    opcode = op;
    repeat (6) @(posedge clk);
    #5;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    idle(3);
    clr = 1'b0;  // R1: first cycle after clear is fetch
    runInstr(4'h0);  // R3
    runInstr(4'h1);  // R4 add
    runInstr(4'h2);  // R4 subtract
    runInstr(4'h3);  // R5
    runInstr(4'h5);  // R7
    runInstr(4'hA);  // R7
    runInstr(4'hE);  // R7
    runInstr(4'h0);
    runInstr(4'h2);
    runInstr(4'h1);
    runInstr(4'h3);
    opcode = 4'hF;   // R6 halt
    idle(10);
    opcode = 4'h1;   // R6: ignored while halted
    idle(5);
    opcode = 4'h3;
    idle(5);
    clr = 1'b1;      // R1 restart after halt
    idle(2);
    clr = 1'b0;
    runInstr(4'h1);
    runInstr(4'h3);
    runInstr(4'h7);
    opcode = 4'hF;
    idle(8);
    clr = 1'b1;      // R1 clear in mid-sequence
    idle(1);
    clr = 1'b0;
    runInstr(4'h2);
    idle(1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule